// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers thirteen level-sensitive interrupt request lines, numbered 1 to 13, and tells the processor which one to serve. Each source owns a control byte that sets both its arbitration key and the interrupt level it presents. A mask register can silence any source, and a read-only pending register shows the sampled request lines. Among the sources that are both pending and unmasked, the one with the largest key wins. The block then drives a 3-bit level and an 8-bit vector number to the processor.

The vector comes from one of two places. If the winning source has its autovector bit set, the vector is derived from its level. Otherwise three sources (the watchdog source and two serial-port sources) take their vector from a programmable vector register, and every other source gets a fixed fallback vector. Software reaches all registers through a simple single-cycle write port and a combinational read port. Acknowledge cycles are handled elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask register reads 0x3FFE, control bytes of sources 1..7 read 4×source number (0x04..0x1C), source 8 reads 0x1C, sources 9..11 read 0x80, sources 12 and 13 read 0x00, the watchdog vector register reads 0x0F, and both outputs are 0.
- R2: A source takes part in arbitration only when its pending bit is 1 and its mask bit is 0; with every pending source masked, level and vector are 0.
- R3: The key of a source is its control byte bits [4:0]; the active source with the strictly largest key wins, so on equal keys the lower-numbered source wins.
- R4: If the winning key is below 4, or no source is active, the level and vector outputs are both 0.
- R5: The presented level is bits [4:2] of the winning source's control byte.
- R6: If bit 7 of the winning control byte is 1, the vector is 24 plus the level.
- R7: If bit 7 is 0, source 8 presents the watchdog vector register, source 12 the first serial vector register, source 13 the second serial vector register, and any other source presents 0x0F.
- R8: Register map (8-bit address, 16-bit data): control byte of source n at 0x13+n (data bits [7:0]), mask at 0x36 (bit n masks source n, bit 0 reads 0), pending at 0x3A (bit n is source n, writes have no effect), watchdog vector at 0x40, first serial vector at 0x41, second serial vector at 0x42; unmapped addresses read 0.
- R9: A register write changes level and vector on the clock edge after the one that stores the write; a change on a request line reaches the pending register one edge later and the outputs one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 13 | Request lines, bit n is source n (bits 13:1) |
| bus_wr | input | 1 | Write strobe, stored on the rising edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_level | output | 3 | Presented interrupt level, 0 means none |
| irq_vector | output | 8 | Presented vector number |

## Verification
The hardest situation to reach is an exact key tie between two active sources whose vectors can be told apart. After reset all sources are masked, and the default keys of the two serial sources are 0 and well below the watchdog source's. The stimulus first loads distinct values into the three vector registers, rewrites the first serial source's control byte to equal the watchdog source's key, and opens the mask for just those two. Then it raises the serial key by one and watches the vector switch over.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the prioritised vectored interrupt controller.
// Assumes 8-bit control bytes and a 16-bit register data path.
package irq_prio_pkg;
    localparam int unsigned CTRL_W = 8;
    localparam int unsigned KEY_W  = 5;
    localparam int unsigned LVL_W  = 3;
    localparam int unsigned VEC_W  = 8;

    localparam logic [7:0] OFS_CTRL_BASE = 8'h14;
    localparam logic [7:0] OFS_MASK      = 8'h36;
    localparam logic [7:0] OFS_PEND      = 8'h3A;
    localparam logic [7:0] OFS_VEC_WDOG  = 8'h40;
    localparam logic [7:0] OFS_VEC_SER0  = 8'h41;
    localparam logic [7:0] OFS_VEC_SER1  = 8'h42;

    localparam logic [VEC_W-1:0] AUTOVEC_BASE = 8'd24;
    localparam logic [VEC_W-1:0] VEC_FALLBACK = 8'h0F;
    localparam logic [VEC_W-1:0] VEC_WDOG_RST = 8'h0F;
    localparam logic [KEY_W-1:0] KEY_MIN      = 5'd4;

    localparam int unsigned SRC_WDOG = 8;
    localparam int unsigned SRC_SER0 = 12;
    localparam int unsigned SRC_SER1 = 13;

    // Reset value of the control byte of a given source number.
    function automatic logic [CTRL_W-1:0] ctrl_reset_val(int unsigned src);
        if (src <= 7)       return CTRL_W'(src * 4);
        else if (src == 8)  return 8'h1C;
        else if (src <= 11) return 8'h80;
        else                return 8'h00;
    endfunction
endpackage

// File: rtl/irq_regs.sv
// Register file: control bytes, mask, sampled pending lines and vector
// registers. Writes are stored on the rising edge; reads are combinational.
// Assumes DATA_W >= NUM_SRC + 1 and DATA_W >= 8.
module irq_regs
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic [NUM_SRC:1]                 src_req,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_SRC:1][CTRL_W-1:0]     ctrl_q,
    output logic [NUM_SRC:1]                 mask_q,
    output logic [NUM_SRC:1]                 pend_q,
    output logic [VEC_W-1:0]                 vec_wdog_q,
    output logic [VEC_W-1:0]                 vec_ser0_q,
    output logic [VEC_W-1:0]                 vec_ser1_q
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_VW   = ADDR_W'(OFS_VEC_WDOG);
    localparam logic [ADDR_W-1:0] A_VS0  = ADDR_W'(OFS_VEC_SER0);
    localparam logic [ADDR_W-1:0] A_VS1  = ADDR_W'(OFS_VEC_SER1);

    // Address of the control byte of source n.
    function automatic logic [ADDR_W-1:0] ctrl_addr(int unsigned n);
        return ADDR_W'(int'(OFS_CTRL_BASE) + int'(n) - 1);
    endfunction

    // Control bytes: reset pattern, then byte writes.
    always_ff @(posedge clk) begin
        for (int unsigned n = 1; n <= NUM_SRC; n++) begin
            if (!rst_n)
                ctrl_q[n] <= ctrl_reset_val(n);
            else if (bus_wr && bus_addr == ctrl_addr(n))
                ctrl_q[n] <= bus_wdata[CTRL_W-1:0];
        end
    end

    // Mask and vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '1;
            vec_wdog_q <= VEC_WDOG_RST;
            vec_ser0_q <= '0;
            vec_ser1_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MASK) mask_q     <= bus_wdata[NUM_SRC:1];
            if (bus_addr == A_VW)   vec_wdog_q <= bus_wdata[VEC_W-1:0];
            if (bus_addr == A_VS0)  vec_ser0_q <= bus_wdata[VEC_W-1:0];
            if (bus_addr == A_VS1)  vec_ser1_q <= bus_wdata[VEC_W-1:0];
        end
    end

    // Pending register follows the level-sensitive request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_req;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MASK) bus_rdata = DATA_W'({mask_q, 1'b0});
        if (bus_addr == A_PEND) bus_rdata = DATA_W'({pend_q, 1'b0});
        if (bus_addr == A_VW)   bus_rdata = DATA_W'(vec_wdog_q);
        if (bus_addr == A_VS0)  bus_rdata = DATA_W'(vec_ser0_q);
        if (bus_addr == A_VS1)  bus_rdata = DATA_W'(vec_ser1_q);
        for (int unsigned n = 1; n <= NUM_SRC; n++)
            if (bus_addr == ctrl_addr(n)) bus_rdata = DATA_W'(ctrl_q[n]);
    end
endmodule

// File: rtl/irq_arbiter.sv
// Combinational arbiter: finds the active source with the strictly largest
// key, scanning upward so ties keep the lower source. Returns 0 when no
// source is active or the best key is below the minimum level key.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1][CTRL_W-1:0] ctrl,
    input  logic [NUM_SRC:1]             active,
    output logic [IDX_W-1:0]             win_idx
);
    logic [KEY_W-1:0] best_key [0:NUM_SRC];
    logic [IDX_W-1:0] best_idx [0:NUM_SRC];

    assign best_key[0] = '0;
    assign best_idx[0] = '0;

    // One compare stage per source.
    for (genvar i = 1; i <= NUM_SRC; i++) begin : g_stage
        logic [KEY_W-1:0] key;
        logic             take;
        assign key         = ctrl[i][KEY_W-1:0];
        assign take        = active[i] && (key > best_key[i-1]);
        assign best_key[i] = take ? key : best_key[i-1];
        assign best_idx[i] = take ? IDX_W'(i) : best_idx[i-1];
    end

    // Below-threshold winners present nothing.
    assign win_idx = (best_key[NUM_SRC] >= KEY_MIN) ? best_idx[NUM_SRC] : '0;
endmodule

// File: rtl/irq_vec_out.sv
// Output stage: turns the winning source and its control byte into a level
// and vector, and registers both. Assumes win_ctrl belongs to win_idx.
module irq_vec_out
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [CTRL_W-1:0] win_ctrl,
    input  logic [VEC_W-1:0]  vec_wdog,
    input  logic [VEC_W-1:0]  vec_ser0,
    input  logic [VEC_W-1:0]  vec_ser1,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [LVL_W-1:0] lvl_d;
    logic [VEC_W-1:0] vec_d;

    // Level and vector selection for the current winner.
    always_comb begin
        lvl_d = '0;
        vec_d = '0;
        if (win_idx != '0) begin
            lvl_d = win_ctrl[4:2];
            if (win_ctrl[7])                          vec_d = AUTOVEC_BASE + VEC_W'(lvl_d);
            else if (win_idx == IDX_W'(SRC_WDOG))     vec_d = vec_wdog;
            else if (win_idx == IDX_W'(SRC_SER0))     vec_d = vec_ser0;
            else if (win_idx == IDX_W'(SRC_SER1))     vec_d = vec_ser1;
            else                                      vec_d = VEC_FALLBACK;
        end
    end

    // Register the presented level and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            irq_level  <= lvl_d;
            irq_vector <= vec_d;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritised vectored interrupt controller: registers, arbiter
// and registered output stage. Assumes request lines are synchronous to clk.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = 13,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC:1]  src_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1][CTRL_W-1:0] ctrl_q;
    logic [NUM_SRC:1]             mask_q;
    logic [NUM_SRC:1]             pend_q;
    logic [VEC_W-1:0]             vec_wdog_q, vec_ser0_q, vec_ser1_q;
    logic [IDX_W-1:0]             win_idx;
    logic [CTRL_W-1:0]            win_ctrl;

    irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .src_req(src_req), .bus_rdata(bus_rdata),
        .ctrl_q(ctrl_q), .mask_q(mask_q), .pend_q(pend_q),
        .vec_wdog_q(vec_wdog_q), .vec_ser0_q(vec_ser0_q), .vec_ser1_q(vec_ser1_q)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .ctrl(ctrl_q), .active(pend_q & ~mask_q), .win_idx(win_idx)
    );

    // Pick out the winner's control byte.
    always_comb begin
        win_ctrl = '0;
        for (int unsigned n = 1; n <= NUM_SRC; n++)
            if (win_idx == IDX_W'(n)) win_ctrl = ctrl_q[n];
    end

    irq_vec_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk(clk), .rst_n(rst_n), .win_idx(win_idx), .win_ctrl(win_ctrl),
        .vec_wdog(vec_wdog_q), .vec_ser0(vec_ser0_q), .vec_ser1(vec_ser1_q),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );
endmodule

// File: rtl/irq_prio_chk.sv
// Property checker for irq_prio_ctrl, attached with bind below.
module irq_prio_chk #(
    parameter int unsigned NUM_SRC = 13,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_SRC:1] src_req,
    input logic [NUM_SRC:1] pend_q,
    input logic [NUM_SRC:1] mask_q,
    input logic [IDX_W-1:0] win_idx,
    input logic [7:0]       win_ctrl,
    input logic [2:0]       irq_level,
    input logic [7:0]       irq_vector
);
    // R1: reset leaves every source masked.
    p_reset_mask_r1: assert property (@(posedge clk)
        !rst_n |=> mask_q == '1);

    // R2: nothing active means nothing presented on the next edge.
    p_quiet_when_inactive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~mask_q) == '0) |=> irq_level == '0);

    // R4: a zero level always comes with a zero vector.
    p_zero_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == '0 |-> irq_vector == '0);

    // R5: presented level comes from the winner's control byte.
    p_level_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_idx != '0 |=> irq_level == $past(win_ctrl[4:2]));

    // R6: autovector winners present 24 plus their level.
    p_autovector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_idx != '0 && win_ctrl[7]) |=> irq_vector == 8'd24 + 8'(irq_level));

    // R9: pending register follows the request lines one edge later.
    p_pend_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(src_req));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .pend_q(pend_q),
    .mask_q(mask_q), .win_idx(win_idx), .win_ctrl(win_ctrl),
    .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/test_irq_prio_ctrl.sv
// Directed bench for irq_prio_ctrl: one task per scenario.
module test_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] src_req = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [7:0] a, int exp);
        bus_addr = a;
        #0.5;
        check(req, int'(bus_rdata), exp);
    endtask

    task automatic out_check(string req, int lvl, int vec);
        check({req, " level"}, int'(irq_level), lvl);
        check({req, " vector"}, int'(irq_vector), vec);
    endtask

    task automatic t_reset();
        out_check("R1 reset", 0, 0);
        rd_check("R1 mask", 8'h36, 16'h3FFE);
        rd_check("R1 ctrl1", 8'h14, 8'h04);
        rd_check("R1 ctrl7", 8'h1A, 8'h1C);
        rd_check("R1 ctrl8", 8'h1B, 8'h1C);
        rd_check("R1 ctrl9", 8'h1C, 8'h80);
        rd_check("R1 ctrl13", 8'h20, 8'h00);
        rd_check("R1 wdog vec", 8'h40, 8'h0F);
    endtask

    task automatic t_masked();
        src_req = '1;
        repeat (2) @(negedge clk);
        out_check("R2 all masked", 0, 0);
        rd_check("R8 pending", 8'h3A, 16'h3FFE);
        wr(8'h3A, 16'h0000);
        rd_check("R8 pending read-only", 8'h3A, 16'h3FFE);
        wr(8'h36, 16'h3FDE);              // unmask source 5 only
        @(negedge clk);
        out_check("R5 R7 source5", 5, 8'h0F);
        wr(8'h36, 16'h3F76);              // sources 3 and 7
        @(negedge clk);
        out_check("R3 larger key", 7, 8'h0F);
    endtask

    task automatic t_vectors();
        wr(8'h40, 16'h0055);
        wr(8'h41, 16'h0066);
        wr(8'h42, 16'h0077);
        wr(8'h1F, 16'h001C);              // source 12 key equals source 8
        wr(8'h36, 16'h2EFE);              // sources 8 and 12
        @(negedge clk);
        out_check("R3 tie lower wins, R7 wdog", 7, 8'h55);
        wr(8'h1F, 16'h001D);
        @(negedge clk);
        out_check("R7 serial0", 7, 8'h66);
        wr(8'h20, 16'h001E);
        wr(8'h36, 16'h0EFE);              // add source 13
        @(negedge clk);
        out_check("R7 serial1", 7, 8'h77);
    endtask

    task automatic t_timing();
        src_req[13] = 1'b0;
        @(negedge clk);
        out_check("R9 line +1", 7, 8'h77);
        @(negedge clk);
        out_check("R9 line +2", 7, 8'h66);
        wr(8'h36, 16'h1EFE);              // mask source 12
        out_check("R9 write +1", 7, 8'h66);
        @(negedge clk);
        out_check("R9 write +2", 7, 8'h55);
    endtask

    task automatic t_threshold();
        wr(8'h14, 16'h0003);
        wr(8'h36, 16'h3FFC);              // source 1 only
        @(negedge clk);
        out_check("R4 key 3", 0, 0);
        wr(8'h14, 16'h0004);
        @(negedge clk);
        out_check("R4 key 4", 1, 8'h0F);
        wr(8'h14, 16'h0084);
        @(negedge clk);
        out_check("R6 auto level1", 1, 25);
        wr(8'h14, 16'h0098);
        @(negedge clk);
        out_check("R6 auto level6", 6, 30);
        wr(8'h36, 16'h3DFE);              // source 9, key 0
        @(negedge clk);
        out_check("R4 key 0", 0, 0);
        rd_check("R8 ctrl1 readback", 8'h14, 8'h98);
        rd_check("R8 unmapped", 8'h00, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_vectors();
        t_timing();
        t_threshold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule